// File: doc/BRIEF.md
# Two-Wire Display Command and Memory Slave

This block is the bus-facing front end of a small segmented display controller. It watches a two-wire serial bus (SCL clock line, SDA open-drain data line) with a fast system clock, recognises start, repeated-start and stop conditions, and responds to a single 7-bit device address. The first byte written after the address is a packed command. That byte sets the display-blank flag, a 2-bit refresh-rate select and a 1-bit flash-rate select, and it loads a 4-bit memory pointer.

Every further written byte goes to a twelve-entry byte memory at the pointer, and the pointer then advances. A read transfers bytes from the memory at the pointer in the same way. A read may follow a command write through a repeated start. It may also begin straight from a start with the read address, and in that case it continues from wherever the pointer was left. Memory entries 0 to 5 carry segment on/off bits and entries 6 to 11 carry per-segment flash enables with the same bit arrangement. The memory itself lives outside the block, which exports an address, a write strobe, write data and a read-data input.

Top module: `lcd_i2c_cmd_slave`

## Requirements
- R1: After the active-low reset, the display-blank flag, refresh select, flash select and pointer are all 0, SDA is released (sda_oe = 0) and no memory write strobe is given.
- R2: The slave acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal DEV_ADDR (default 7'b0111001), with bit 0 as read(1)/write(0). On any other address it releases SDA and writes nothing until the next start.
- R3: In a write, the first byte after the address sets blank = bit 7 (1 = display blanked), refresh select = bits 6:5, flash select = bit 4 and pointer = bits 3:0.
- R4: Each written byte after the command byte produces exactly one single-cycle write strobe at the current pointer, and then the pointer advances by one.
- R5: The pointer advancing from 11 goes to 0, so an automatic advance never yields 12 to 15.
- R6: A read entered through a repeated start after a command write returns memory bytes MSB first, starting at the pointer that the command loaded.
- R7: A read that opens directly with the read address starts at the pointer left by earlier transfers, and it leaves the command fields unchanged.
- R8: Each byte sent in a read advances the pointer. After a master NACK the slave stops driving SDA, and a stop always leaves SDA released.
- R9: The command byte and every data byte of a write are acknowledged.
- R10: The slave changes its SDA drive only while the synchronised SCL is low, and drives SDA only in acknowledge and read-data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain) |
| disp_blank | output | 1 | Display-blank flag from command bit 7 |
| refresh_sel | output | 2 | Refresh-rate select from command bits 6:5 |
| flash_sel | output | 1 | Flash-rate select from command bit 4 |
| mem_addr | output | 4 | Memory address (current pointer) |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data for mem_addr |

## Verification
The hardest situation to reach is a read that starts without a command byte, because its first byte depends on where every earlier transfer left the pointer, including a wrap through 11. The stimulus chains random write bursts, repeated-start reads and bare reads of random length and start point. It tracks the pointer in a bench model, so each bare read lands at a position set by what came before. Directed cases force the wrap, a wrong address and a NACK followed by a stop.

// File: rtl/lcd_i2c_pkg.sv
package lcd_i2c_pkg;

    localparam int MEM_DEPTH = 12;
    localparam int PTR_W     = 4;
    localparam int BYTE_W    = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_WCMD,
        PH_WDATA,
        PH_WACK,
        PH_RDATA,
        PH_RACK
    } phase_e;

    // Pointer advance with wrap after the last memory entry.
    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        if (p >= PTR_W'(MEM_DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/lcd_i2c_line_sync.sv
module lcd_i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.scl_pipe = {st_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        st_d.sda_pipe = {st_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        st_d.scl_prev = st_q.scl_pipe[SYNC_STAGES-1];
        st_d.sda_prev = st_q.sda_pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign scl_s     = st_q.scl_pipe[SYNC_STAGES-1];
    assign sda_s     = st_q.sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~st_q.scl_prev;
    assign scl_fall  = ~scl_s & st_q.scl_prev;
    assign start_det = scl_s & st_q.scl_prev & st_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & st_q.scl_prev & ~st_q.sda_prev & sda_s;
endmodule

// File: rtl/lcd_i2c_engine.sv
module lcd_i2c_engine
    import lcd_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0111001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              sda_oe,
    output logic [3:0]        ctl,
    output logic [PTR_W-1:0]  ptr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output phase_e            phase
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        phase_e             ph;
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic               rw;
        logic               nack;
        logic [3:0]         ctl;
        logic [PTR_W-1:0]   ptr;
        logic               oe;
    } eng_s;

    eng_s st_d, st_q;
    logic we_d;
    logic byte_end;

    assign byte_end = scl_fall && (st_q.cnt == CNT_W'(BYTE_W));

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (stop_det) begin
            st_d.ph = PH_IDLE;
            st_d.oe = 1'b0;
        end else if (start_det) begin
            st_d.ph  = PH_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else begin
            unique case (st_q.ph)
                PH_ADDR, PH_WCMD, PH_WDATA: begin
                    if (scl_rise) begin
                        st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end else if (byte_end) begin
                        if (st_q.ph == PH_ADDR) begin
                            if (st_q.sh[7:1] == DEV_ADDR) begin
                                st_d.ph = PH_AACK;
                                st_d.oe = 1'b1;
                                st_d.rw = st_q.sh[0];
                            end else begin
                                st_d.ph = PH_IDLE;
                            end
                        end else if (st_q.ph == PH_WCMD) begin
                            st_d.ctl = st_q.sh[7:4];
                            st_d.ptr = st_q.sh[3:0];
                            st_d.ph  = PH_WACK;
                            st_d.oe  = 1'b1;
                        end else begin
                            we_d     = 1'b1;
                            st_d.ptr = ptr_step(st_q.ptr);
                            st_d.ph  = PH_WACK;
                            st_d.oe  = 1'b1;
                        end
                    end
                end
                PH_AACK: begin
                    if (scl_fall) begin
                        st_d.cnt = '0;
                        if (st_q.rw) begin
                            st_d.ph = PH_RDATA;
                            st_d.sh = mem_rdata;
                            st_d.oe = ~mem_rdata[BYTE_W-1];
                        end else begin
                            st_d.ph = PH_WCMD;
                            st_d.oe = 1'b0;
                        end
                    end
                end
                PH_WACK: begin
                    if (scl_fall) begin
                        st_d.ph  = PH_WDATA;
                        st_d.oe  = 1'b0;
                        st_d.cnt = '0;
                    end
                end
                PH_RDATA: begin
                    if (scl_rise) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end else if (byte_end) begin
                        st_d.oe  = 1'b0;
                        st_d.ptr = ptr_step(st_q.ptr);
                        st_d.ph  = PH_RACK;
                    end else if (scl_fall) begin
                        st_d.sh = {st_q.sh[BYTE_W-2:0], 1'b0};
                        st_d.oe = ~st_q.sh[BYTE_W-2];
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        st_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (st_q.nack) begin
                            st_d.ph = PH_IDLE;
                        end else begin
                            st_d.ph  = PH_RDATA;
                            st_d.cnt = '0;
                            st_d.sh  = mem_rdata;
                            st_d.oe  = ~mem_rdata[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, sh: '0, cnt: '0, rw: 1'b0, nack: 1'b0,
                      ctl: '0, ptr: '0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe    = st_q.oe;
    assign ctl       = st_q.ctl;
    assign ptr       = st_q.ptr;
    assign mem_we    = we_d;
    assign mem_wdata = st_q.sh;
    assign phase     = st_q.ph;
endmodule

// File: rtl/lcd_i2c_cmd_slave.sv
module lcd_i2c_cmd_slave
    import lcd_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0111001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              disp_blank,
    output logic [1:0]        refresh_sel,
    output logic              flash_sel,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0] ctl;
    phase_e phase;

    lcd_i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    lcd_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .ctl       (ctl),
        .ptr       (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .phase     (phase)
    );

    assign disp_blank  = ctl[3];
    assign refresh_sel = ctl[2:1];
    assign flash_sel   = ctl[0];
endmodule

// File: rtl/lcd_i2c_cmd_slave_chk.sv
module lcd_i2c_cmd_slave_chk
    import lcd_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr,
    input logic             scl_s,
    input logic             stop_det,
    input phase_e           phase
);
    // R4: one strobe per byte
    a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: pointer steps by one after a write below the top entry
    a_r4_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr < PTR_W'(MEM_DEPTH - 1)) |=> (mem_addr == $past(mem_addr) + PTR_W'(1)));

    // R5: wrap after the last entry
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == PTR_W'(MEM_DEPTH - 1)) |=> (mem_addr == '0));

    // R8: stop leaves SDA released
    a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: drive changes only with SCL low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R10: drive only in acknowledge or read-data phases
    a_r10_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (phase == PH_AACK || phase == PH_WACK || phase == PH_RDATA));
endmodule

bind lcd_i2c_cmd_slave lcd_i2c_cmd_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .phase    (phase)
);

// File: tb/lcd_i2c_cmd_slave_test.sv
`timescale 1ns/1ps
module lcd_i2c_cmd_slave_test;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'b0111001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, disp_blank, flash_sel, mem_we;
    logic [1:0] refresh_sel;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_bus;

    logic [7:0] mem [12];
    logic [7:0] exp_mem [12];
    int exp_ptr = 0;
    logic [3:0] exp_ctl = '0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = (mem_addr < 4'd12) ? mem[mem_addr] : 8'h00;

    always @(posedge clk) if (mem_we && mem_addr < 4'd12) mem[mem_addr] <= mem_wdata;

    lcd_i2c_cmd_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .disp_blank(disp_blank), .refresh_sel(refresh_sel),
        .flash_sel(flash_sel), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int nxt(input int p);
        return (p >= 11) ? 0 : p + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_bus; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(~give_ack);
    endtask

    task automatic chk_ctl(input string req);
        chk(disp_blank == exp_ctl[3] && refresh_sel == exp_ctl[2:1] && flash_sel == exp_ctl[0],
            req, {disp_blank, refresh_sel, flash_sel}, exp_ctl);
    endtask

    // Command write plus n data bytes (R3, R4, R5, R9)
    task automatic do_write(input logic [7:0] cmd, input int n, input bit stop);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R2 addr ack", ack, 1);
        send_byte(cmd, ack);         chk(ack, "R9 cmd ack", ack, 1);
        exp_ctl = cmd[7:4]; exp_ptr = cmd[3:0];
        chk_ctl("R3 command fields");
        for (int i = 0; i < n; i++) begin
            logic [7:0] v = 8'($urandom);
            send_byte(v, ack); chk(ack, "R9 data ack", ack, 1);
            exp_mem[exp_ptr] = v;
            chk(mem[exp_ptr] == v, "R4 stored byte", mem[exp_ptr], v);
            exp_ptr = nxt(exp_ptr);
        end
        if (stop) bus_stop();
    endtask

    // Read n bytes; caller supplies the start or repeated start (R6, R7, R8)
    task automatic do_read(input int n, input string req);
        logic ack;
        logic [7:0] v;
        send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(v == exp_mem[exp_ptr], req, v, exp_mem[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
        end
        chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 release after stop", sda_oe, 0);
        chk_ctl("R7 read keeps command");
    endtask

    initial begin
        logic ack;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 12; i++) begin
            mem[i] = 8'(i * 17 + 3); exp_mem[i] = 8'(i * 17 + 3);
        end
        wq(5);
        // R1: reset state
        chk(sda_oe == 0 && mem_we == 0, "R1 reset drive", {sda_oe, mem_we}, 0);
        chk_ctl("R1 reset command");
        chk(mem_addr == 0, "R1 reset pointer", mem_addr, 0);
        rst_n = 1; wq(5);

        // R2: wrong address ignored
        bus_start();
        send_byte({7'b0111000, 1'b0}, ack);
        chk(!ack, "R2 mismatch no ack", ack, 0);
        send_byte(8'hF3, ack);
        chk(!ack, "R2 mismatch no ack on data", ack, 0);
        bus_stop();
        chk_ctl("R2 mismatch leaves command");
        chk(mem_addr == 0, "R2 mismatch leaves pointer", mem_addr, 0);

        // R3/R5: command 0xDA sets blank=1 refresh=2 flash=1 pointer=10, wrap
        do_write(8'hDA, 4, 1);
        chk(mem_addr == 2, "R5 wrap pointer", mem_addr, 2);

        // R6: repeated-start read from pointer 9 through the wrap
        do_write(8'h29, 0, 0);
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
        do_read(4, "R6 read after command");

        // R7: bare read continues at pointer 1
        bus_start();
        do_read(2, "R7 bare read");
        chk(mem_addr == 4'(exp_ptr), "R8 pointer after read", mem_addr, exp_ptr);

        // Random mix
        for (int t = 0; t < 14; t++) begin
            int kind = int'($urandom_range(0, 2));
            int n    = int'($urandom_range(1, 7));
            logic [7:0] cmd = {4'($urandom), 4'($urandom_range(0, 11))};
            if (kind == 0) begin
                do_write(cmd, n, 1);
            end else if (kind == 1) begin
                do_write(cmd, 0, 0);
                sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
                do_read(n, "R6 random read");
            end else begin
                bus_start();
                do_read(n, "R7 random bare read");
            end
            chk(mem_addr == 4'(exp_ptr), "R5 pointer track", mem_addr, exp_ptr);
        end

        for (int i = 0; i < 12; i++)
            chk(mem[i] == exp_mem[i], "R4 final memory", mem[i], exp_mem[i]);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule